// File: doc/BRIEF.md
# Memory Access Permission Classifier

This block sits in front of address translation and decides, for every memory access, whether the access may proceed and which physical address it uses. Each access brings a 32-bit virtual address, an access kind (load, store or fetch), a privilege flag and the result of a translation lookup that is done elsewhere. The lookup result is a hit flag, a physical page number and read, write and execute permission bits.

The decision is combinational. It produces either a physical address or a fault with a cause code. Some fixed high address windows skip translation for privileged code and are barred to unprivileged code. When a real access faults, three fault registers capture their new values on the next clock edge, and a strobe reports the capture for one cycle. The registers are the faulting address, the virtual page number and a flag that tells data accesses from fetches. A probe access gets the same verdict but never writes these registers.

A build-time switch removes translation completely. The address then passes through unchanged and no fault is raised.

Top module: `mmu_access_classifier`

## Requirements
- R1: When built without translation (`MMU_ON` = 0), `phys_addr` equals `virt_addr`, `fault` stays low and `fault_cause` stays 0 for every input, and `upd_strobe` never rises.
- R2: With translation, a privileged access (`priv_mode`=1) at or above 0xC0000000 does not fault, and `phys_addr` equals `virt_addr`, whatever the lookup reports.
- R3: An unprivileged access at or above 0x80000000 faults before any lookup is used. The cause is 1 for a fetch and 2 for a load or store. Of the fault registers, only `bad_addr_q` is captured.
- R4: A lookup hit with the needed permission does not fault. The needed permission is read for a load (`acc_kind`=0), write for a store (1) and execute for a fetch (2). `phys_addr` is `{tlb_ppn, virt_addr[11:0]}`. A privileged access below 0xC0000000 also takes this path.
- R5: A hit without the needed permission faults with cause 5 for a load, 6 for a store and 7 for a fetch.
- R6: A lookup miss faults with cause 3 for a fetch and cause 4 for a load or store.
- R7: A captured miss or permission fault (causes 3 to 7) loads three registers. `bad_addr_q` takes the full address, `vpn_q` takes `virt_addr[31:12]`, and `dflag_q` is set to 1 for a load or store and 0 for a fetch.
- R8: When `probe` is high, `fault` and `fault_cause` still show the verdict, but the fault registers keep their values and `upd_strobe` stays low.
- R9: The fault registers are captured only in a cycle where `req_valid` is high and a fault is shown. `upd_strobe` is high for exactly the cycle after that capture.
- R10: While `fault` is high, `phys_addr` is 0. After a synchronous reset (`rst_n` low at a clock edge), `bad_addr_q`, `vpn_q`, `dflag_q` and `upd_strobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| virt_addr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| priv_mode | input | 1 | Privileged (1) or unprivileged (0) access |
| probe | input | 1 | Verdict only, no register capture |
| tlb_hit | input | 1 | Lookup found a mapping |
| tlb_ppn | input | 20 | Physical page number from the lookup |
| tlb_rd | input | 1 | Mapping allows reads |
| tlb_wr | input | 1 | Mapping allows writes |
| tlb_ex | input | 1 | Mapping allows execution |
| phys_addr | output | 32 | Physical address, 0 on a fault |
| fault | output | 1 | Access faults |
| fault_cause | output | 3 | Cause code, 0 when there is no fault |
| bad_addr_q | output | 32 | Captured faulting address |
| vpn_q | output | 20 | Captured virtual page number |
| dflag_q | output | 1 | Captured data-access flag |
| upd_strobe | output | 1 | One-cycle pulse after a capture |

## Verification
The assertions assume that `acc_kind` never carries the unused value 3. They also assume that lookup inputs and `virt_addr` are known whenever reset is released. The cycle checks compare against the previous cycle, so they also rely on `req_valid` and `probe` being driven as steady levels between clock edges. The bench changes every input at the falling edge and uses only the three defined access kinds. Outside reset it holds all inputs at known values, so the assertions are never exercised outside those assumptions.

// File: rtl/mmuc_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the access classifier.
// Assumes: access kind 3 is never presented.
package mmuc_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_PRIV_INST  = 3'd1,
        CAUSE_PRIV_DATA  = 3'd2,
        CAUSE_MISS_INST  = 3'd3,
        CAUSE_MISS_DATA  = 3'd4,
        CAUSE_PERM_READ  = 3'd5,
        CAUSE_PERM_WRITE = 3'd6,
        CAUSE_PERM_EXEC  = 3'd7
    } cause_e;
endpackage

// File: rtl/mmuc_region_check.sv
`timescale 1ns/1ps
// Decides from the address and privilege alone whether an access skips
// translation (privileged high window) or is barred (unprivileged high window).
// Assumes: KERNEL_BASE >= USER_TOP, so the two windows never conflict.
module mmuc_region_check #(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] KERNEL_BASE = 32'hC000_0000,
    parameter logic [31:0] USER_TOP    = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv,
    output logic              bypass,
    output logic              barred
);
    // Compare the address against both window limits.
    always_comb begin
        bypass = priv  && (addr >= KERNEL_BASE[ADDR_W-1:0]);
        barred = !priv && (addr >= USER_TOP[ADDR_W-1:0]);
    end
endmodule

// File: rtl/mmuc_perm_check.sv
`timescale 1ns/1ps
// Picks the permission bit the access kind needs and names the fault
// that a hit lacking it, or a miss, would raise.
// Assumes: kind is one of load, store, fetch.
module mmuc_perm_check
    import mmuc_pkg::*;
(
    input  acc_e   kind,
    input  logic   perm_rd,
    input  logic   perm_wr,
    input  logic   perm_ex,
    output logic   allowed,
    output cause_e perm_cause,
    output cause_e miss_cause
);
    // Select needed permission and the matching fault codes.
    always_comb begin
        unique case (kind)
            ACC_STORE: begin
                allowed    = perm_wr;
                perm_cause = CAUSE_PERM_WRITE;
                miss_cause = CAUSE_MISS_DATA;
            end
            ACC_FETCH: begin
                allowed    = perm_ex;
                perm_cause = CAUSE_PERM_EXEC;
                miss_cause = CAUSE_MISS_INST;
            end
            default: begin
                allowed    = perm_rd;
                perm_cause = CAUSE_PERM_READ;
                miss_cause = CAUSE_MISS_DATA;
            end
        endcase
    end
endmodule

// File: rtl/mmuc_fault_regs.sv
`timescale 1ns/1ps
// Holds the fault-capture registers: faulting address, virtual page number
// and data-access flag, plus a one-cycle capture strobe.
// Assumes: cap_en already excludes probes and idle cycles.
module mmuc_fault_regs #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_xlate,
    input  logic              cap_is_data,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic [ADDR_W-1:0] bad_addr_q,
    output logic [VPN_W-1:0]  vpn_q,
    output logic              dflag_q,
    output logic              strobe_q
);
    // Capture on a reported fault; translation faults also load page and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_addr_q <= '0;
            vpn_q      <= '0;
            dflag_q    <= 1'b0;
            strobe_q   <= 1'b0;
        end else begin
            strobe_q <= cap_en;
            if (cap_en) begin
                bad_addr_q <= cap_addr;
                if (cap_xlate) begin
                    vpn_q   <= cap_addr[ADDR_W-1:PAGE_BITS];
                    dflag_q <= cap_is_data;
                end
            end
        end
    end
endmodule

// File: rtl/mmu_access_classifier.sv
`timescale 1ns/1ps
// Classifies each access as a pass (with physical address) or a fault with
// cause, and captures fault registers for non-probe faults.
// Assumes: lookup result is valid in the same cycle as the address.
module mmu_access_classifier
    import mmuc_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          PAGE_BITS   = 12,
    parameter bit          MMU_ON      = 1'b1,
    parameter logic [31:0] KERNEL_BASE = 32'hC000_0000,
    parameter logic [31:0] USER_TOP    = 32'h8000_0000,
    localparam int         VPN_W       = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] virt_addr,
    input  logic [1:0]        acc_kind,
    input  logic              priv_mode,
    input  logic              probe,
    input  logic              tlb_hit,
    input  logic [VPN_W-1:0]  tlb_ppn,
    input  logic              tlb_rd,
    input  logic              tlb_wr,
    input  logic              tlb_ex,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              fault,
    output logic [2:0]        fault_cause,
    output logic [ADDR_W-1:0] bad_addr_q,
    output logic [VPN_W-1:0]  vpn_q,
    output logic              dflag_q,
    output logic              upd_strobe
);
    acc_e   kind;
    cause_e cause;
    logic   xlate_fault;
    logic   cap_en;

    assign kind = acc_e'(acc_kind);

    generate
        if (MMU_ON) begin : gen_mmu
            logic   bypass, barred, allowed;
            cause_e perm_cause, miss_cause;

            mmuc_region_check #(
                .ADDR_W(ADDR_W), .KERNEL_BASE(KERNEL_BASE), .USER_TOP(USER_TOP)
            ) region_i (
                .addr(virt_addr), .priv(priv_mode),
                .bypass(bypass), .barred(barred)
            );

            mmuc_perm_check perm_i (
                .kind(kind), .perm_rd(tlb_rd), .perm_wr(tlb_wr), .perm_ex(tlb_ex),
                .allowed(allowed), .perm_cause(perm_cause), .miss_cause(miss_cause)
            );

            // Priority: window bypass, window bar, hit with permission, hit, miss.
            always_comb begin
                phys_addr   = '0;
                cause       = CAUSE_NONE;
                xlate_fault = 1'b0;
                if (bypass) begin
                    phys_addr = virt_addr;
                end else if (barred) begin
                    cause = (kind == ACC_FETCH) ? CAUSE_PRIV_INST : CAUSE_PRIV_DATA;
                end else if (tlb_hit && allowed) begin
                    phys_addr = {tlb_ppn, virt_addr[PAGE_BITS-1:0]};
                end else if (tlb_hit) begin
                    cause       = perm_cause;
                    xlate_fault = 1'b1;
                end else begin
                    cause       = miss_cause;
                    xlate_fault = 1'b1;
                end
            end

            assert_priv_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (priv_mode && virt_addr >= KERNEL_BASE[ADDR_W-1:0])
                    |-> (!fault && phys_addr == virt_addr));

            assert_user_barred_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!priv_mode && virt_addr >= USER_TOP[ADDR_W-1:0])
                    |-> (fault && (fault_cause == 3'd1 || fault_cause == 3'd2)));

            assert_hit_address_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!fault && virt_addr < USER_TOP[ADDR_W-1:0])
                    |-> (tlb_hit && phys_addr == {tlb_ppn, virt_addr[PAGE_BITS-1:0]}));
        end else begin : gen_bare
            logic unused_lookup;
            // Identity mapping; the lookup result plays no part.
            always_comb begin
                phys_addr     = virt_addr;
                cause         = CAUSE_NONE;
                xlate_fault   = 1'b0;
                unused_lookup = ^{tlb_hit, tlb_ppn, tlb_rd, tlb_wr, tlb_ex, priv_mode};
            end

            assert_bare_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |-> (!fault && phys_addr == virt_addr && !upd_strobe));
        end
    endgenerate

    // Drive fault outputs and the capture enable.
    always_comb begin
        fault_cause = cause;
        fault       = (cause != CAUSE_NONE);
        cap_en      = req_valid && fault && !probe;
    end

    mmuc_fault_regs #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_xlate(xlate_fault),
        .cap_is_data(kind != ACC_FETCH), .cap_addr(virt_addr),
        .bad_addr_q(bad_addr_q), .vpn_q(vpn_q), .dflag_q(dflag_q),
        .strobe_q(upd_strobe)
    );

    assert_probe_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && probe) |=> (!upd_strobe && $stable(bad_addr_q) && $stable(vpn_q)));

    assert_page_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !probe && fault_cause >= 3'd3)
            |=> (vpn_q == $past(virt_addr[ADDR_W-1:PAGE_BITS]) && bad_addr_q == $past(virt_addr)));

    assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |=> !upd_strobe);

    assert_fault_zero_pa_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (phys_addr == '0));
endmodule

// File: tb/mmu_access_classifier_tb_top.sv
`timescale 1ns/1ps
module mmu_access_classifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] virt_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        priv_mode = 1'b0;
    logic        probe = 1'b0;
    logic        tlb_hit = 1'b0;
    logic [19:0] tlb_ppn = '0;
    logic        tlb_rd = 1'b0, tlb_wr = 1'b0, tlb_ex = 1'b0;

    logic [31:0] phys_addr, bad_addr_q, b_phys, b_bad;
    logic        fault, dflag_q, upd_strobe, b_fault, b_dflag, b_strobe;
    logic [2:0]  fault_cause, b_cause;
    logic [19:0] vpn_q, b_vpn;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mmu_access_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .virt_addr(virt_addr),
        .acc_kind(acc_kind), .priv_mode(priv_mode), .probe(probe),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd(tlb_rd), .tlb_wr(tlb_wr),
        .tlb_ex(tlb_ex), .phys_addr(phys_addr), .fault(fault),
        .fault_cause(fault_cause), .bad_addr_q(bad_addr_q), .vpn_q(vpn_q),
        .dflag_q(dflag_q), .upd_strobe(upd_strobe)
    );

    mmu_access_classifier #(.MMU_ON(1'b0)) dut_bare_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .virt_addr(virt_addr),
        .acc_kind(acc_kind), .priv_mode(priv_mode), .probe(probe),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd(tlb_rd), .tlb_wr(tlb_wr),
        .tlb_ex(tlb_ex), .phys_addr(b_phys), .fault(b_fault),
        .fault_cause(b_cause), .bad_addr_q(b_bad), .vpn_q(b_vpn),
        .dflag_q(b_dflag), .upd_strobe(b_strobe)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  acc;
        logic        priv;
        logic        hit;
        logic [19:0] ppn;
        logic        r;
        logic        w;
        logic        x;
        logic [2:0]  cause;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1234, 2'd0, 1'b0, 1'b1, 20'h00ABC, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00AB_C234}, // R4 load
        '{32'h0000_5678, 2'd1, 1'b0, 1'b1, 20'h12345, 1'b0, 1'b1, 1'b0, 3'd0, 32'h1234_5678}, // R4 store
        '{32'h0040_0FFF, 2'd2, 1'b0, 1'b1, 20'h00001, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_1FFF}, // R4 fetch
        '{32'h0000_2000, 2'd0, 1'b0, 1'b1, 20'h00007, 1'b0, 1'b1, 1'b1, 3'd5, 32'h0},         // R5 read
        '{32'h0000_3004, 2'd1, 1'b0, 1'b1, 20'h00007, 1'b1, 1'b0, 1'b1, 3'd6, 32'h0},         // R5 write
        '{32'h0000_4008, 2'd2, 1'b0, 1'b1, 20'h00007, 1'b1, 1'b1, 1'b0, 3'd7, 32'h0},         // R5 exec
        '{32'h1234_5678, 2'd0, 1'b0, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 3'd4, 32'h0},         // R6 load miss
        '{32'h7FFF_FFFC, 2'd1, 1'b0, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 3'd4, 32'h0},         // R6 store miss
        '{32'h0010_0000, 2'd2, 1'b0, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 3'd3, 32'h0},         // R6 fetch miss
        '{32'h8000_0000, 2'd0, 1'b0, 1'b1, 20'h00009, 1'b1, 1'b1, 1'b1, 3'd2, 32'h0},         // R3 data
        '{32'hFFFF_0000, 2'd2, 1'b0, 1'b1, 20'h00009, 1'b1, 1'b1, 1'b1, 3'd1, 32'h0},         // R3 inst
        '{32'hC000_0010, 2'd1, 1'b0, 1'b0, 20'h0,     1'b0, 1'b0, 1'b0, 3'd2, 32'h0},         // R3 store
        '{32'hC000_0010, 2'd0, 1'b1, 1'b0, 20'h0,     1'b0, 1'b0, 1'b0, 3'd0, 32'hC000_0010}, // R2 load
        '{32'hFFFF_FFF0, 2'd2, 1'b1, 1'b0, 20'h0,     1'b0, 1'b0, 1'b0, 3'd0, 32'hFFFF_FFF0}, // R2 fetch
        '{32'h8000_1000, 2'd0, 1'b1, 1'b1, 20'h00055, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0005_5000}, // R4 priv
        '{32'hBFFF_F000, 2'd1, 1'b1, 1'b0, 20'h0,     1'b1, 1'b1, 1'b1, 3'd4, 32'h0},         // R6 priv
        '{32'h9000_0004, 2'd2, 1'b1, 1'b1, 20'h00001, 1'b1, 1'b1, 1'b0, 3'd7, 32'h0}          // R5 priv
    };

    logic [31:0] exp_bad = '0;
    logic [19:0] exp_vpn = '0;
    logic        exp_dflag = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic pr, input logic vld);
        virt_addr = v.va; acc_kind = v.acc; priv_mode = v.priv; tlb_hit = v.hit;
        tlb_ppn = v.ppn; tlb_rd = v.r; tlb_wr = v.w; tlb_ex = v.x;
        probe = pr; req_valid = vld;
    endtask

    task automatic chk_regs(input string req, input logic strobe_exp);
        chk(req, {31'd0, upd_strobe}, {31'd0, strobe_exp});
        chk(req, bad_addr_q, exp_bad);
        chk(req, {12'd0, vpn_q}, {12'd0, exp_vpn});
        chk(req, {31'd0, dflag_q}, {31'd0, exp_dflag});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk_regs("R10 reset", 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i], 1'b0, 1'b1);
            #1;
            chk($sformatf("R2-6 vec%0d cause", i), {29'd0, fault_cause}, {29'd0, VECS[i].cause});
            chk($sformatf("R10 vec%0d fault", i), {31'd0, fault}, {31'd0, VECS[i].cause != 3'd0});
            chk($sformatf("R4 vec%0d pa", i), phys_addr, VECS[i].pa);
            chk($sformatf("R1 vec%0d bare", i), b_phys, VECS[i].va);
            if (VECS[i].cause != 3'd0) begin
                exp_bad = VECS[i].va;
                if (VECS[i].cause >= 3'd3) begin
                    exp_vpn   = VECS[i].va[31:12];
                    exp_dflag = (VECS[i].acc != 2'd2);
                end
            end
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk_regs($sformatf("R7 vec%0d regs", i), VECS[i].cause != 3'd0);
            chk($sformatf("R1 vec%0d bare strobe", i), {31'd0, b_strobe | b_fault}, 32'd0);
        end

        // R9: strobe lasts a single cycle
        @(negedge clk); #1;
        chk_regs("R9 strobe drop", 1'b0);

        // R8: probe keeps registers untouched but still reports
        @(negedge clk);
        drive('{32'h0000_6000, 2'd1, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 3'd4, 32'h0}, 1'b1, 1'b1);
        #1;
        chk("R8 probe cause", {29'd0, fault_cause}, 32'd4);
        @(negedge clk); req_valid = 1'b0; probe = 1'b0; #1;
        chk_regs("R8 probe regs", 1'b0);

        // R9: fault without req_valid is not captured
        @(negedge clk);
        drive('{32'h0000_7000, 2'd2, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 3'd3, 32'h0}, 1'b0, 1'b0);
        @(negedge clk); #1;
        chk_regs("R9 idle fault", 1'b0);

        // R3: barred access keeps page and flag
        @(negedge clk);
        exp_vpn = 20'h00000; exp_dflag = 1'b0;
        drive('{32'h0000_8000, 2'd2, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 3'd3, 32'h0}, 1'b0, 1'b1);
        exp_bad = 32'h0000_8000; exp_vpn = 20'h00008; exp_dflag = 1'b0;
        @(negedge clk);
        drive('{32'hA000_0000, 2'd0, 1'b0, 1'b1, 20'h1, 1'b1, 1'b1, 1'b1, 3'd2, 32'h0}, 1'b0, 1'b1);
        exp_bad = 32'hA000_0000;
        @(negedge clk); req_valid = 1'b0; #1;
        chk_regs("R3 only bad addr", 1'b1);

        // R10: synchronous reset mid-run clears registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        exp_bad = '0; exp_vpn = '0; exp_dflag = 1'b0;
        chk_regs("R10 reset again", 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule